// File: doc/BRIEF.md
# Multi-Domain Clock Source Selector and Divider

This block produces four derived clocks for a small controller, one each for the processor, the serial bus engine, the interval timer and the capture timer. It also drives a clock-out pin from a choice of sources. It accepts three raw sources: an external clock, an internal 24 MHz reference and a 32 kHz low-power reference. For each domain, a small register file holds the source choice and the division ratio. Software writes these registers through a one-cycle write strobe.

All logic runs on one fast sampling clock `clk`, and the source clocks arrive as level signals sampled by it. Each divider is a three-state machine. In state PASS the selected source passes through unchanged (ratio 1). State HIGH is the high phase of a divided output, and state LOW is its low phase. The machine moves only on a sampled rising edge of its source. The transitions are:

- PASS→PASS when the ratio stays 1.
- PASS→HIGH or HIGH/LOW→HIGH on a wrap, when the new ratio is 2 or more.
- HIGH→LOW when the edge count reaches half the ratio.
- LOW→LOW while counting.
- HIGH/LOW→PASS on a wrap that picks up ratio 1.

The capture-timer clock can itself be chosen as the interval timer's source.

Top module: `ckd_clock_unit`

## Requirements
- R1: After reset every domain and the clock-out pin select the internal 24 MHz reference. The processor and timer ratios are 1 and the bus-clock halving is on, so the bus clock has twice the reference period and the other outputs match the reference period.
- R2: Register 0 bit 0 picks the processor source: 0 is the internal reference, 1 is the external clock.
- R3: Register 0 bits [3:1] hold code n, and the processor clock period is the source period times 2^n for n in 0–5 or 7, with a 50% duty cycle for n ≥ 1.
- R4: Code n = 6 divides by 128, the same as n = 7.
- R5: Register 1 bit 0 picks the bus-clock source (0 internal, 1 external). Bit 1 set halves it, and bit 1 clear passes the source period.
- R6: Register 2 bits [1:0] pick the interval-timer source: 0 internal, 1 external, 2 low-power, 3 capture-timer clock.
- R7: Register 2 bits [3:2] hold p, and the interval-timer period is the source period times p+1. With p+1 = 3 the output is high for one source period. With even ratios it is high for half the period.
- R8: Register 3 bits [1:0] pick the capture-timer source: 0 internal, 1 external, 2 low-power, 3 internal.
- R9: Register 3 bits [3:2] pick the clock-out source: 0 internal, 1 external, 2 low-power, 3 divided processor clock.
- R10: A new ratio takes effect only at the source edge where the divider's count wraps to zero, so the output period in progress completes at the old ratio.
- R11: A ratio of 1 reproduces the selected source's waveform, period and high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext | input | 1 | External clock level |
| src_int | input | 1 | Internal 24 MHz reference level |
| src_lp | input | 1 | 32 kHz low-power reference level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index 0–3 |
| cfg_wdata | input | 8 | Register write data |
| cpu_clk_o | output | 1 | Divided processor clock |
| usb_clk_o | output | 1 | Bus-engine clock |
| itmr_clk_o | output | 1 | Prescaled interval-timer clock |
| cap_clk_o | output | 1 | Capture-timer clock |
| clk_out_o | output | 1 | Clock-out pin |

## Verification
The function most likely to collide with another is a register write that lands while a divider is mid-count. The write changes the requested ratio, while the counter decides on the same source edge whether it wraps and picks up that ratio. To provoke this, the bench runs the processor divider at 128, waits for a rising output edge, and at once writes a ratio of 2. It then checks that the running period still measures 128 source periods with its full high half, and that only the following periods are short. Every other setting is judged by measuring the rising-edge spacing and high time of each output against the chosen source period times the programmed ratio.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_t;

    typedef struct packed {
        logic       cpu_ext;
        logic [2:0] cpu_n;
        logic       usb_ext;
        logic       usb_half;
        logic [1:0] it_src;
        logic [1:0] it_pre;
        logic [1:0] cap_src;
        logic [1:0] out_src;
    } ckd_cfg_t;

    // processor ratio: 2^n, with the unused code 6 folded onto 7
    function automatic logic [7:0] cpu_ratio_of(input logic [2:0] n);
        logic [2:0] e;
        e = (n == 3'd6) ? 3'd7 : n;
        return 8'd1 << e;
    endfunction

endpackage

// File: rtl/ckd_cfg_regs.sv
module ckd_cfg_regs
    import ckd_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ckd_cfg_t      cfg
);

    localparam ckd_cfg_t CFG_RST = '{
        cpu_ext: 1'b0, cpu_n: 3'd0, usb_ext: 1'b0, usb_half: 1'b1,
        it_src: 2'd0, it_pre: 2'd0, cap_src: 2'd0, out_src: 2'd0
    };

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RST;
        end else if (we) begin
            unique case (addr)
                AW'(0): begin
                    cfg.cpu_ext <= wdata[0];
                    cfg.cpu_n   <= wdata[3:1];
                end
                AW'(1): begin
                    cfg.usb_ext  <= wdata[0];
                    cfg.usb_half <= wdata[1];
                end
                AW'(2): begin
                    cfg.it_src <= wdata[1:0];
                    cfg.it_pre <= wdata[3:2];
                end
                default: begin
                    cfg.cap_src <= wdata[1:0];
                    cfg.out_src <= wdata[3:2];
                end
            endcase
        end
    end

endmodule

// File: rtl/ckd_src_mux.sv
module ckd_src_mux #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  srcs,
    input  logic [SW-1:0] sel,
    output logic          out_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) out_o <= 1'b0;
        else        out_o <= srcs[sel];
    end

endmodule

// File: rtl/ckd_divider.sv
module ckd_divider
    import ckd_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src,
    input  logic [RW-1:0] ratio,
    output logic          div_o
);

    localparam logic [RW-1:0] ONE = RW'(1);

    logic          src_q;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] rat_q, rat_d;
    div_state_t    st_q, st_d;
    logic          rise, at_wrap;

    assign rise    = src & ~src_q;
    assign at_wrap = (cnt_q == rat_q - ONE);

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rat_d = rat_q;
        if (rise) begin
            if (at_wrap) begin
                cnt_d = '0;
                rat_d = (ratio == '0) ? ONE : ratio;
                st_d  = (rat_d == ONE) ? ST_PASS : ST_HIGH;
            end else begin
                cnt_d = cnt_q + ONE;
                st_d  = (cnt_d < (rat_q >> 1)) ? ST_HIGH : ST_LOW;
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            cnt_q <= '0;
            rat_q <= ONE;
            st_q  <= ST_PASS;
        end else begin
            src_q <= src;
            cnt_q <= cnt_d;
            rat_q <= rat_d;
            st_q  <= st_d;
        end
    end

    // output process
    always_comb begin
        unique case (st_q)
            ST_PASS: div_o = src_q;
            ST_HIGH: div_o = 1'b1;
            ST_LOW:  div_o = 1'b0;
            default: div_o = 1'b0;
        endcase
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < rat_q);

    assert_ratio_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rat_q != $past(rat_q)) |-> (cnt_q == '0));

    assert_pass_unity_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PASS) |-> (rat_q == ONE));

endmodule

// File: rtl/ckd_clock_unit.sv
module ckd_clock_unit
    import ckd_pkg::*;
#(
    parameter int AW     = 2,
    parameter int DW     = 8,
    parameter int CPU_RW = 8,
    parameter int TMR_RW = 3,
    parameter int USB_RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_ext,
    input  logic          src_int,
    input  logic          src_lp,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          cpu_clk_o,
    output logic          usb_clk_o,
    output logic          itmr_clk_o,
    output logic          cap_clk_o,
    output logic          clk_out_o
);

    localparam int SEL2 = 1;
    localparam int SEL4 = 2;

    ckd_cfg_t cfg;
    logic cpu_src, usb_src, it_src;
    logic [CPU_RW-1:0] cpu_ratio;
    logic [TMR_RW-1:0] it_ratio;
    logic [USB_RW-1:0] usb_ratio;

    ckd_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    assign cpu_ratio = CPU_RW'(cpu_ratio_of(cfg.cpu_n));
    assign it_ratio  = TMR_RW'(cfg.it_pre) + TMR_RW'(1);
    assign usb_ratio = cfg.usb_half ? USB_RW'(2) : USB_RW'(1);

    // source selection
    ckd_src_mux #(.N(2), .SW(SEL2)) u_cpu_mux (
        .clk(clk), .rst_n(rst_n), .srcs({src_ext, src_int}),
        .sel(cfg.cpu_ext), .out_o(cpu_src)
    );
    ckd_src_mux #(.N(2), .SW(SEL2)) u_usb_mux (
        .clk(clk), .rst_n(rst_n), .srcs({src_ext, src_int}),
        .sel(cfg.usb_ext), .out_o(usb_src)
    );
    ckd_src_mux #(.N(4), .SW(SEL4)) u_cap_mux (
        .clk(clk), .rst_n(rst_n), .srcs({src_int, src_lp, src_ext, src_int}),
        .sel(cfg.cap_src), .out_o(cap_clk_o)
    );
    ckd_src_mux #(.N(4), .SW(SEL4)) u_it_mux (
        .clk(clk), .rst_n(rst_n), .srcs({cap_clk_o, src_lp, src_ext, src_int}),
        .sel(cfg.it_src), .out_o(it_src)
    );
    ckd_src_mux #(.N(4), .SW(SEL4)) u_out_mux (
        .clk(clk), .rst_n(rst_n), .srcs({cpu_clk_o, src_lp, src_ext, src_int}),
        .sel(cfg.out_src), .out_o(clk_out_o)
    );

    // dividers
    ckd_divider #(.RW(CPU_RW)) u_cpu_div (
        .clk(clk), .rst_n(rst_n), .src(cpu_src), .ratio(cpu_ratio), .div_o(cpu_clk_o)
    );
    ckd_divider #(.RW(USB_RW)) u_usb_div (
        .clk(clk), .rst_n(rst_n), .src(usb_src), .ratio(usb_ratio), .div_o(usb_clk_o)
    );
    ckd_divider #(.RW(TMR_RW)) u_it_div (
        .clk(clk), .rst_n(rst_n), .src(it_src), .ratio(it_ratio), .div_o(itmr_clk_o)
    );

    assert_cpu_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cpu_ratio) == 1);

    assert_code6_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cpu_n == 3'd6) |-> (cpu_ratio == CPU_RW'(128)));

    assert_usb_ratio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_ratio == USB_RW'(1)) || (usb_ratio == USB_RW'(2)));

    assert_it_ratio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (it_ratio >= TMR_RW'(1)) && (it_ratio <= TMR_RW'(4)));

endmodule

// File: tb/ckd_clock_unit_test.sv
`timescale 1ns/1ps
module ckd_clock_unit_test;

    localparam int PI = 4;   // internal reference period, in clk cycles
    localparam int PE = 6;   // external clock period
    localparam int PL = 10;  // low-power reference period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_ext = 1'b0, src_int = 1'b0, src_lp = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic cpu_clk_o, usb_clk_o, itmr_clk_o, cap_clk_o, clk_out_o;
    logic [4:0] outs;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int tick = 0;

    typedef struct {
        int    ch;
        int    per;
        int    hi;
        string tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ckd_clock_unit uut (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .src_int(src_int), .src_lp(src_lp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cpu_clk_o(cpu_clk_o), .usb_clk_o(usb_clk_o), .itmr_clk_o(itmr_clk_o),
        .cap_clk_o(cap_clk_o), .clk_out_o(clk_out_o)
    );

    assign outs = {clk_out_o, cap_clk_o, itmr_clk_o, usb_clk_o, cpu_clk_o};

    always @(negedge clk) begin
        tick    <= tick + 1;
        src_int <= (tick % PI) < (PI / 2);
        src_ext <= (tick % PE) < (PE / 2);
        src_lp  <= (tick % PL) < (PL / 2);
    end

    task automatic wait_rise(input int ch);
        logic p, hit;
        p = outs[ch];
        do begin
            @(negedge clk);
            hit = outs[ch] && !p;
            p = outs[ch];
        end while (!hit);
    endtask

    // called right after a rise sample; returns cycles to next rise and high samples
    task automatic span(input int ch, output int per, output int hi);
        logic p, cur;
        per = 0; hi = 1; p = 1'b1;
        forever begin
            @(negedge clk);
            per++;
            cur = outs[ch];
            if (cur && !p) break;
            if (cur) hi++;
            p = cur;
        end
    endtask

    task automatic judge(input string tag, input int ch, input int per, input int hi,
                         input int eper, input int ehi);
        n_chk++;
        if (per != eper || hi != ehi) begin
            n_bad++;
            $display("FAIL %s ch%0d period %0d exp %0d, high %0d exp %0d",
                     tag, ch, per, eper, hi, ehi);
        end
    endtask

    // monitor: pops expected items and compares measured waveforms
    initial begin
        forever begin
            int per, hi;
            item_t it;
            wait (sb.size() > 0);
            it = sb[0];
            for (int k = 0; k < 3; k++) wait_rise(it.ch);
            span(it.ch, per, hi);
            judge(it.tag, it.ch, per, hi, it.per, it.hi);
            sb.pop_front();
        end
    end

    task automatic expect_clk(input int ch, input int per, input int hi, input string tag);
        item_t it;
        it.ch = ch; it.per = per; it.hi = hi; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int hi_of(input int src_per, input int r);
        if (r == 1) return src_per / 2;
        if (r == 3) return src_per;
        return src_per * r / 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int srcp[3];
        int per, hi;
        srcp[0] = PI; srcp[1] = PE; srcp[2] = PL;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset defaults
        expect_clk(0, PI, PI/2, "R1 cpu");
        expect_clk(1, 2*PI, PI, "R1 usb");
        expect_clk(2, PI, PI/2, "R1 itmr");
        expect_clk(3, PI, PI/2, "R1 cap");
        expect_clk(4, PI, PI/2, "R11 clkout");

        // R2: processor source
        wr(0, 1);
        expect_clk(0, PE, PE/2, "R2 ext");
        wr(0, 0);
        expect_clk(0, PI, PI/2, "R2 int");

        // R3: 2^n codes
        for (int n = 0; n < 8; n++) begin
            if (n == 6) continue;
            wr(0, n << 1);
            expect_clk(0, PI << n, (PI << n) / 2, n == 0 ? "R11 cpu n0" : "R3 cpu");
        end
        wr(0, (3 << 1) | 1);
        expect_clk(0, PE * 8, PE * 4, "R3 ext n3");

        // R4: code 6 acts as 7
        wr(0, 6 << 1);
        expect_clk(0, PI * 128, PI * 64, "R4 code6");

        // R5: bus clock
        wr(1, 0);
        expect_clk(1, PI, PI/2, "R5 int nohalf");
        wr(1, 2);
        expect_clk(1, 2*PI, PI, "R5 int half");
        wr(1, 1);
        expect_clk(1, PE, PE/2, "R5 ext nohalf");
        wr(1, 3);
        expect_clk(1, 2*PE, PE, "R5 ext half");

        // R6 / R7: interval timer source and prescale
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                wr(2, (p << 2) | s);
                expect_clk(2, srcp[s] * (p + 1), hi_of(srcp[s], p + 1),
                           p == 0 ? "R6 itmr src" : "R7 itmr prescale");
            end
        end
        wr(3, 2);            // capture on low-power
        for (int p = 0; p < 4; p++) begin
            wr(2, (p << 2) | 3);
            expect_clk(2, PL * (p + 1), hi_of(PL, p + 1), "R6 itmr from capture");
        end

        // R8: capture source
        for (int s = 0; s < 4; s++) begin
            wr(3, s);
            expect_clk(3, (s == 3) ? PI : srcp[s], ((s == 3) ? PI : srcp[s]) / 2, "R8 cap");
        end

        // R9: clock-out source
        wr(0, (2 << 1) | 1); // processor: external / 4
        for (int s = 0; s < 4; s++) begin
            wr(3, s << 2);
            if (s == 3) expect_clk(4, PE * 4, PE * 2, "R9 clkout cpu");
            else        expect_clk(4, srcp[s], srcp[s] / 2, "R9 clkout src");
        end

        // R10: ratio change mid-count finishes the running period
        wr(0, 7 << 1);
        for (int k = 0; k < 3; k++) wait_rise(0);
        wait_rise(0);
        fork
            wr(0, 1 << 1);
        join_none
        span(0, per, hi);
        judge("R10 running period", 0, per, hi, PI * 128, PI * 64);
        span(0, per, hi);
        judge("R10 new ratio", 0, per, hi, PI * 2, PI);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule